// File: doc/BRIEF.md
# Palette Pixel Output Stage

This block turns raster position into color. A separate timing generator, running on the pixel clock, supplies the horizontal and vertical position, an active-high blank flag and two active-low syncs. For every active position the block reads an 8-bit pixel from a frame buffer. That pixel is either an index into a 256-entry table of 24-bit colors or, when the table is bypassed, a packed 3-3-2 color. The block then drives active-high 8-bit red, green and blue outputs, one pixel per clock.

The frame buffer and the color table each have their own synchronous write port, so a processor can update image or palette while the display side reads. The syncs and blank are delayed by the same two clocks as the color path, which keeps them aligned with the pixels they belong to. An 8-color mode reduces each channel to one bit. A 3-bit output always carries the top bit of each channel, which suits a resistor-network output.

Top module: `pix_out_stage`

## Requirements
- R1: While reset is low, and on the first clock after it, red, green, blue and colorBits are zero, blankOut is 1, and hSyncNOut and vSyncNOut are 1.
- R2: For an active position, the frame-buffer word read is at address vPos*H_ACTIVE + hPos. fbWrAddr uses the same word addressing.
- R3: With useLut=1, the output color is the table entry indexed by the pixel: red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R4: With useLut=0, pixel bits 7:5 give red, bits 4:2 give green and bits 1:0 give blue. Each field is widened to 8 bits by repeating its bits from the MSB down: red and green as {f,f,f[2:1]}, blue as {b,b,b,b}.
- R5: The color, hSyncNOut, vSyncNOut and blankOut outputs show the effect of the inputs presented two clocks earlier.
- R6: When the delayed blank is 1, red, green, blue and colorBits are all zero.
- R7: With eightColor=1, each 8-bit channel is 8'hFF if that channel's MSB is 1 and 8'h00 otherwise. colorBits is always {red[7], green[7], blue[7]}.
- R8: If a write hits the frame-buffer word or the table entry being read in the same clock, the read returns the old contents. The new value is seen from the next read on.
- R9: useLut and eightColor travel through the pipeline with the position, so each can change on every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hPos | input | HPOS_W | Horizontal position |
| vPos | input | VPOS_W | Vertical position |
| blankIn | input | 1 | Blanking flag, high outside the active area |
| hSyncNIn | input | 1 | Horizontal sync, active low |
| vSyncNIn | input | 1 | Vertical sync, active low |
| useLut | input | 1 | 1 = pixel is a table index, 0 = packed 3-3-2 color |
| eightColor | input | 1 | 1 = one-bit-per-channel mode |
| fbWrEn | input | 1 | Frame-buffer write enable |
| fbWrAddr | input | ADDR_W | Frame-buffer word address |
| fbWrData | input | 8 | Pixel to write |
| lutWrEn | input | 1 | Color-table write enable |
| lutWrAddr | input | 8 | Color-table index |
| lutWrData | input | 24 | Color {R,G,B} to write |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |
| colorBits | output | 3 | {red MSB, green MSB, blue MSB} |
| hSyncNOut | output | 1 | Delayed horizontal sync, active low |
| vSyncNOut | output | 1 | Delayed vertical sync, active low |
| blankOut | output | 1 | Delayed blank |

## Verification
A processor write and a display read can land on the same location in the same clock, in either memory. To provoke this, a scan line writes, on every active clock, the frame-buffer word being fetched in that clock, and writes the table entry indexed by the pixel that is one stage deeper. The reference model applies writes only after it has made the reads of that edge, so every output in that line is judged against the old contents. Later lines are judged against the new contents.

// File: rtl/pix_out_pkg.sv
package pix_out_pkg;
  localparam int PIX_W      = 8;
  localparam int CH_W       = 8;
  localparam int RGB_W      = 3 * CH_W;
  localparam int LUT_DEPTH  = 1 << PIX_W;
  localparam int PIPE_DEPTH = 2;   // frame-buffer read + table read

  typedef struct packed {
    logic fbRead;   // stage 0: fetch a pixel this clock
    logic lutSel;   // stage 2: color comes from the table
    logic eight;    // stage 2: one bit per channel
    logic blank;    // stage 2: force colors to zero
  } pxStrobe_t;
endpackage

// File: rtl/pix_out_ctrl.sv
module pix_out_ctrl
  import pix_out_pkg::*;
#(
  parameter int H_ACTIVE = 32,
  parameter int FB_DEPTH = 768,
  parameter int HPOS_W   = 11,
  parameter int VPOS_W   = 10,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HPOS_W-1:0] hPos,
  input  logic [VPOS_W-1:0] vPos,
  input  logic              blankIn,
  input  logic              hSyncNIn,
  input  logic              vSyncNIn,
  input  logic              useLut,
  input  logic              eightColor,
  output logic [ADDR_W-1:0] rdAddr,
  output pxStrobe_t         strobe,
  output logic              hSyncNOut,
  output logic              vSyncNOut,
  output logic              blankOut
);
  logic [PIPE_DEPTH-1:0] blankSr, hSyncSr, vSyncSr, lutSr, eightSr;
  logic [1:0] validCnt;

  always_comb begin
    rdAddr = '0;
    if (!blankIn) rdAddr = ADDR_W'(32'(vPos) * 32'(H_ACTIVE) + 32'(hPos));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blankSr  <= '1;
      hSyncSr  <= '1;
      vSyncSr  <= '1;
      lutSr    <= '0;
      eightSr  <= '0;
      validCnt <= '0;
    end else begin
      blankSr <= {blankSr[PIPE_DEPTH-2:0], blankIn};
      hSyncSr <= {hSyncSr[PIPE_DEPTH-2:0], hSyncNIn};
      vSyncSr <= {vSyncSr[PIPE_DEPTH-2:0], vSyncNIn};
      lutSr   <= {lutSr[PIPE_DEPTH-2:0], useLut};
      eightSr <= {eightSr[PIPE_DEPTH-2:0], eightColor};
      if (validCnt != 2'd2) validCnt <= validCnt + 2'd1;
    end
  end

  always_comb begin
    strobe.fbRead = !blankIn;
    strobe.lutSel = lutSr[PIPE_DEPTH-1];
    strobe.eight  = eightSr[PIPE_DEPTH-1];
    strobe.blank  = blankSr[PIPE_DEPTH-1];
  end

  assign hSyncNOut = hSyncSr[PIPE_DEPTH-1];
  assign vSyncNOut = vSyncSr[PIPE_DEPTH-1];
  assign blankOut  = blankSr[PIPE_DEPTH-1];

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (blankOut && hSyncNOut && vSyncNOut));

  assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (validCnt == 2'd2) |-> (hSyncNOut == $past(hSyncNIn, 2) &&
                            vSyncNOut == $past(vSyncNIn, 2) &&
                            blankOut  == $past(blankIn, 2)));

  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fbRead |-> (32'(rdAddr) < FB_DEPTH));
endmodule

// File: rtl/pix_out_dp.sv
module pix_out_dp
  import pix_out_pkg::*;
#(
  parameter int FB_DEPTH = 768,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pxStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              fbWrEn,
  input  logic [ADDR_W-1:0] fbWrAddr,
  input  logic [PIX_W-1:0]  fbWrData,
  input  logic              lutWrEn,
  input  logic [PIX_W-1:0]  lutWrAddr,
  input  logic [RGB_W-1:0]  lutWrData,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   green,
  output logic [CH_W-1:0]   blue,
  output logic [2:0]        colorBits
);
  logic [PIX_W-1:0] fbMem  [FB_DEPTH];
  logic [RGB_W-1:0] lutMem [LUT_DEPTH];
  logic [PIX_W-1:0] pixQ, pixQ2;
  logic [RGB_W-1:0] lutQ;
  logic [CH_W-1:0]  baseR, baseG, baseB;

  always_ff @(posedge clk) begin
    if (fbWrEn) fbMem[fbWrAddr] <= fbWrData;
  end

  always_ff @(posedge clk) begin
    if (lutWrEn) lutMem[lutWrAddr] <= lutWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixQ  <= '0;
      pixQ2 <= '0;
    end else begin
      if (strobe.fbRead) pixQ <= fbMem[rdAddr];
      pixQ2 <= pixQ;
    end
  end

  always_ff @(posedge clk) begin
    lutQ <= lutMem[pixQ];
  end

  always_comb begin
    if (strobe.lutSel) begin
      baseR = lutQ[23:16];
      baseG = lutQ[15:8];
      baseB = lutQ[7:0];
    end else begin
      baseR = {pixQ2[7:5], pixQ2[7:5], pixQ2[7:6]};
      baseG = {pixQ2[4:2], pixQ2[4:2], pixQ2[4:3]};
      baseB = {4{pixQ2[1:0]}};
    end
    if (strobe.eight) begin
      baseR = {CH_W{baseR[CH_W-1]}};
      baseG = {CH_W{baseG[CH_W-1]}};
      baseB = {CH_W{baseB[CH_W-1]}};
    end
    if (strobe.blank) begin
      red   = '0;
      green = '0;
      blue  = '0;
    end else begin
      red   = baseR;
      green = baseG;
      blue  = baseB;
    end
    colorBits = {red[CH_W-1], green[CH_W-1], blue[CH_W-1]};
  end

  assert_blank_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.blank |-> (red == '0 && green == '0 && blue == '0 && colorBits == 3'b000));

  assert_eight_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.eight && !strobe.blank) |->
      ((red == '0 || red == '1) && (green == '0 || green == '1) &&
       (blue == '0 || blue == '1)));
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage
  import pix_out_pkg::*;
#(
  parameter int H_ACTIVE = 32,
  parameter int V_ACTIVE = 24,
  parameter int HPOS_W   = 11,
  parameter int VPOS_W   = 10,
  localparam int FB_DEPTH = H_ACTIVE * V_ACTIVE,
  localparam int ADDR_W   = $clog2(FB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HPOS_W-1:0] hPos,
  input  logic [VPOS_W-1:0] vPos,
  input  logic              blankIn,
  input  logic              hSyncNIn,
  input  logic              vSyncNIn,
  input  logic              useLut,
  input  logic              eightColor,
  input  logic              fbWrEn,
  input  logic [ADDR_W-1:0] fbWrAddr,
  input  logic [7:0]        fbWrData,
  input  logic              lutWrEn,
  input  logic [7:0]        lutWrAddr,
  input  logic [23:0]       lutWrData,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue,
  output logic [2:0]        colorBits,
  output logic              hSyncNOut,
  output logic              vSyncNOut,
  output logic              blankOut
);
  pxStrobe_t         strobe;
  logic [ADDR_W-1:0] rdAddr;

  pix_out_ctrl #(
    .H_ACTIVE(H_ACTIVE), .FB_DEPTH(FB_DEPTH),
    .HPOS_W(HPOS_W), .VPOS_W(VPOS_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .hPos(hPos), .vPos(vPos),
    .blankIn(blankIn), .hSyncNIn(hSyncNIn), .vSyncNIn(vSyncNIn),
    .useLut(useLut), .eightColor(eightColor),
    .rdAddr(rdAddr), .strobe(strobe),
    .hSyncNOut(hSyncNOut), .vSyncNOut(vSyncNOut), .blankOut(blankOut)
  );

  pix_out_dp #(.FB_DEPTH(FB_DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdAddr(rdAddr),
    .fbWrEn(fbWrEn), .fbWrAddr(fbWrAddr), .fbWrData(fbWrData),
    .lutWrEn(lutWrEn), .lutWrAddr(lutWrAddr), .lutWrData(lutWrData),
    .red(red), .green(green), .blue(blue), .colorBits(colorBits)
  );
endmodule

// File: tb/pix_out_stage_tb.sv
module pix_out_stage_tb_top;
  localparam int HA = 32;
  localparam int VA = 24;
  localparam int DEPTH = HA * VA;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] hPos = '0;
  logic [9:0]  vPos = '0;
  logic blankIn = 1'b1, hSyncNIn = 1'b1, vSyncNIn = 1'b1;
  logic useLut = 1'b0, eightColor = 1'b0;
  logic fbWrEn = 1'b0, lutWrEn = 1'b0;
  logic [AW-1:0] fbWrAddr = '0;
  logic [7:0] fbWrData = '0, lutWrAddr = '0;
  logic [23:0] lutWrData = '0;
  logic [7:0] red, green, blue;
  logic [2:0] colorBits;
  logic hSyncNOut, vSyncNOut, blankOut;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit armed = 1'b0;

  logic [7:0]  fbM  [DEPTH];
  logic [23:0] lutM [256];
  // reference pipeline
  logic m1Blank, m1Hs, m1Vs, m1Lut, m1Eight; logic [7:0] m1Pix;
  logic m2Blank, m2Hs, m2Vs, m2Lut, m2Eight; logic [7:0] m2Pix; logic [23:0] m2Tab;

  always #2.5 clk = ~clk;

  pix_out_stage dut_i (
    .clk(clk), .rst_n(rst_n), .hPos(hPos), .vPos(vPos), .blankIn(blankIn),
    .hSyncNIn(hSyncNIn), .vSyncNIn(vSyncNIn), .useLut(useLut), .eightColor(eightColor),
    .fbWrEn(fbWrEn), .fbWrAddr(fbWrAddr), .fbWrData(fbWrData),
    .lutWrEn(lutWrEn), .lutWrAddr(lutWrAddr), .lutWrData(lutWrData),
    .red(red), .green(green), .blue(blue), .colorBits(colorBits),
    .hSyncNOut(hSyncNOut), .vSyncNOut(vSyncNOut), .blankOut(blankOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] expColor();
    logic [7:0] r, g, b;
    if (m2Blank) return 24'h0;
    if (m2Lut) {r, g, b} = m2Tab;
    else begin
      r = {m2Pix[7:5], m2Pix[7:5], m2Pix[7:6]};
      g = {m2Pix[4:2], m2Pix[4:2], m2Pix[4:3]};
      b = {4{m2Pix[1:0]}};
    end
    if (m2Eight) begin
      r = r[7] ? 8'hFF : 8'h00;
      g = g[7] ? 8'hFF : 8'h00;
      b = b[7] ? 8'hFF : 8'h00;
    end
    return {r, g, b};
  endfunction

  // reference model: reads of an edge happen before that edge's writes (R8)
  always @(posedge clk) begin
    if (!rst_n) begin
      m1Blank = 1; m1Hs = 1; m1Vs = 1; m1Lut = 0; m1Eight = 0; m1Pix = 0;
      m2Blank = 1; m2Hs = 1; m2Vs = 1; m2Lut = 0; m2Eight = 0; m2Pix = 0; m2Tab = 0;
    end else begin
      m2Blank = m1Blank; m2Hs = m1Hs; m2Vs = m1Vs; m2Lut = m1Lut; m2Eight = m1Eight;
      m2Pix = m1Pix; m2Tab = lutM[m1Pix];
      m1Blank = blankIn; m1Hs = hSyncNIn; m1Vs = vSyncNIn; m1Lut = useLut; m1Eight = eightColor;
      if (!blankIn) m1Pix = fbM[int'(vPos) * HA + int'(hPos)];
    end
    if (fbWrEn) fbM[fbWrAddr] = fbWrData;
    if (lutWrEn) lutM[lutWrAddr] = lutWrData;
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (armed) begin
      logic [23:0] e;
      string tag;
      e = expColor();
      tag = m2Blank ? {phase, " R6"} : phase;
      chk("R5 blank", 32'(blankOut), 32'(m2Blank));
      chk("R5 hsync", 32'(hSyncNOut), 32'(m2Hs));
      chk("R5 vsync", 32'(vSyncNOut), 32'(m2Vs));
      chk({tag, " color"}, {8'h0, red, green, blue}, 32'(e));
      chk("R7 colorBits", 32'(colorBits), 32'({e[23], e[15], e[7]}));
    end
  end

  task automatic scanLine(input int v, input bit lutMode, input bit eightMode,
                          input bit toggle, input bit collide);
    for (int h = 0; h < HA + 6; h++) begin
      @(negedge clk);
      hPos = 11'(h);
      vPos = 10'(v);
      blankIn = (h >= HA);
      hSyncNIn = !(h == HA + 2 || h == HA + 3);
      vSyncNIn = !(v == 5);
      useLut = toggle ? h[0] : lutMode;
      eightColor = toggle ? h[1] : eightMode;
      fbWrEn = collide && (h < HA);
      fbWrAddr = AW'(v * HA + h);
      fbWrData = 8'(h * 13 + v * 7 + 1);
      lutWrEn = collide;
      lutWrAddr = m1Pix;
      lutWrData = 24'(h * 24'h010305 + 24'h804020);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    phase = "R1";
    chk("R1 red", 32'(red), 0);
    chk("R1 colorBits", 32'(colorBits), 0);
    chk("R1 blank", 32'(blankOut), 1);
    chk("R1 hsync", 32'(hSyncNOut), 1);
    chk("R1 vsync", 32'(vSyncNOut), 1);
    armed = 1'b1;
    rst_n = 1'b1;
    // fill memories while blanked
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      fbWrEn = 1; fbWrAddr = AW'(i); fbWrData = 8'(i * 37 + 5);
      lutWrEn = (i < 256); lutWrAddr = 8'(i);
      lutWrData = {8'(i), 8'(~i), 8'(i ^ 8'h5A)};
    end
    @(negedge clk);
    fbWrEn = 0; lutWrEn = 0;
    phase = "R2 R3";
    for (int v = 0; v < 3; v++) scanLine(v, 1, 0, 0, 0);
    phase = "R2 R4";
    for (int v = 3; v < 7; v++) scanLine(v, 0, 0, 0, 0);
    phase = "R7";
    scanLine(7, 1, 1, 0, 0);
    scanLine(8, 0, 1, 0, 0);
    phase = "R9";
    scanLine(9, 0, 0, 1, 0);
    scanLine(23, 0, 0, 1, 0);
    phase = "R8";
    scanLine(10, 1, 0, 0, 1);
    phase = "R8 after";
    fbWrEn = 0; lutWrEn = 0;
    scanLine(10, 1, 0, 0, 0);
    scanLine(10, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule